// File: doc/BRIEF.md
# Pixel Format Expander

This block sits behind the fetch stage of a graphics plane. It takes one fetched pixel word and turns it into a single 8-bit-per-channel ARGB value, so that the blending stages downstream only ever see one pixel layout. The source layout comes from a plane control word. A 5-bit code picks one of seven packed layouts. Three modifier bits then pick the byte order, an exchange of the red and blue channels, and whether an 8-bit alpha field spans 0..255 or 0..128.

For each pixel the upstream fetcher presents the word and the control word with a one-cycle strobe. One clock later the expanded pixel appears at the registered output, with its own valid. A control word that names no supported layout raises a flag and yields a transparent black pixel. Between strobes the output holds its last value.

Top module: `pix_fmt_expand`

## Requirements
- R1: The format code is `in_ctl[4:0]`. The output is packed as alpha `[31:24]`, red `[23:16]`, green `[15:8]` and blue `[7:0]`. Code 0 (16-bit, R[15:11] G[10:5] B[4:0]), code 1 (24-bit, R[23:16] G[15:8] B[7:0]) and code 2 (32-bit, same colour bytes as code 1, with bits [31:24] ignored) all give output alpha 0xFF.
- R2: Code 4 is 24-bit, with A[23:16] R[15:11] G[10:5] B[4:0]. Code 5 is 32-bit, with A[31:24] R[23:16] G[15:8] B[7:0].
- R3: Code 6 is 16-bit, with A[15] R[14:10] G[9:5] B[4:0]; its alpha bit gives 0x00 or 0xFF. Code 7 is 16-bit, with A[15:12] R[11:8] G[7:4] B[3:0]; its alpha is widened by repeating the nibble.
- R4: A field narrower than 8 bits is widened by repeating its bits from the top down into the low bits. For example, 5-bit 10000b gives 0x84, all ones gives 0xFF and zero gives 0x00.
- R5: When `in_ctl[23]` is set, the byte order of the pixel's significant bytes is reversed before any field is extracted. Codes 0, 6 and 7 have 2 significant bytes, codes 1 and 4 have 3, and codes 2 and 5 have 4.
- R6: When `in_ctl[6]` is set, the red and blue output channels are exchanged. Combined with `in_ctl[23]`, this gives the BGR-ordered variants of codes 2 and 5.
- R7: For codes 4 and 5, `in_ctl[5]` set passes the 8-bit alpha through unchanged. With `in_ctl[5]` clear, the alpha is first clamped to 128, then doubled, and 128 gives 0xFF.
- R8: Code 3, or any code above 7, gives output 0x00000000 and sets `out_unknown`. A known code clears the flag.
- R9: `out_valid` equals `in_valid` delayed by exactly one clock. The data and the flag are captured only on a strobe and hold otherwise.
- R10: During reset, `out_valid`, `out_argb` and `out_unknown` are all zero.
- R11: `in_ctl[5]` has no effect on codes 0, 1, 2, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel strobe |
| in_word | input | 32 | Fetched pixel word |
| in_ctl | input | CTL_W (32) | Plane control word |
| out_valid | output | 1 | Output pixel valid |
| out_argb | output | 32 | Expanded ARGB8888 pixel |
| out_unknown | output | 1 | Unsupported format code flag |

## Verification
The bench builds the block with its default values: a 32-bit control word and 8-bit output channels. With these values every format code, both byte orders, the channel exchange and both alpha ranges can be reached through the control port. Alpha values are chosen on each side of the 128 clamp point and at the clamp point itself. Field values are chosen to show the bit-repeat pattern. Codes 3 and 8 are driven to exercise the unknown flag.

// File: rtl/pix_fmt_pkg.sv
package pix_fmt_pkg;

  localparam int CH_W      = 8;
  localparam int NUM_CH    = 4;
  localparam int WORD_W    = CH_W * NUM_CH;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = WORD_W / BYTE_W;

  localparam int CTL_FMT_LSB   = 0;
  localparam int CTL_FMT_W     = 5;
  localparam int CTL_ARANGE    = 5;
  localparam int CTL_RB_SWAP   = 6;
  localparam int CTL_BIG_END   = 23;

  typedef enum logic [CTL_FMT_W-1:0] {
    FMT_RGB565   = 5'd0,
    FMT_RGB888   = 5'd1,
    FMT_XRGB     = 5'd2,
    FMT_ARGB8565 = 5'd4,
    FMT_ARGB8888 = 5'd5,
    FMT_ARGB1555 = 5'd6,
    FMT_ARGB4444 = 5'd7
  } pix_fmt_e;

  typedef enum logic [1:0] {
    ALPHA_OPAQUE,
    ALPHA_SCALED,
    ALPHA_DIRECT
  } alpha_kind_e;

  typedef struct packed {
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } argb_t;

  // Widen the low w bits of v to CH_W bits by repeating the field top-down.
  function automatic logic [CH_W-1:0] widen(input logic [CH_W-1:0] v, input int w);
    logic [CH_W-1:0] res;
    for (int i = 0; i < CH_W; i++) begin
      res[CH_W-1-i] = v[w-1-(i % w)];
    end
    return res;
  endfunction

  // Number of significant bytes per layout, used for byte reversal.
  function automatic logic [2:0] sig_bytes(input logic [CTL_FMT_W-1:0] code);
    case (code)
      FMT_RGB565, FMT_ARGB1555, FMT_ARGB4444: return 3'd2;
      FMT_RGB888, FMT_ARGB8565:               return 3'd3;
      default:                                return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/pix_rst_sync.sv
module pix_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pix_byte_order.sv
module pix_byte_order
  import pix_fmt_pkg::*;
(
  input  logic [WORD_W-1:0]    word_in,
  input  logic                 big_end,
  input  logic [CTL_FMT_W-1:0] fmt_code,
  output logic [WORD_W-1:0]    word_out
);
  logic [WORD_W-1:0] rev [2:NUM_BYTES];

  // One reversed view per significant-byte count.
  for (genvar nb = 2; nb <= NUM_BYTES; nb++) begin : g_view
    for (genvar bi = 0; bi < nb; bi++) begin : g_byte
      assign rev[nb][bi*BYTE_W +: BYTE_W] = word_in[(nb-1-bi)*BYTE_W +: BYTE_W];
    end
    if (nb < NUM_BYTES) begin : g_pad
      assign rev[nb][WORD_W-1:nb*BYTE_W] = '0;
    end
  end

  always_comb begin
    if (!big_end) begin
      word_out = word_in;
    end else begin
      case (sig_bytes(fmt_code))
        3'd2:    word_out = rev[2];
        3'd3:    word_out = rev[3];
        default: word_out = rev[NUM_BYTES];
      endcase
    end
  end
endmodule

// File: rtl/pix_chan_unpack.sv
module pix_chan_unpack
  import pix_fmt_pkg::*;
(
  input  logic [WORD_W-1:0]    word,
  input  logic [CTL_FMT_W-1:0] fmt_code,
  output argb_t                chans,
  output alpha_kind_e          a_kind,
  output logic                 known
);
  always_comb begin
    chans  = '0;
    a_kind = ALPHA_OPAQUE;
    known  = 1'b1;
    case (fmt_code)
      FMT_RGB565: begin
        chans.r = widen(CH_W'(word[15:11]), 5);
        chans.g = widen(CH_W'(word[10:5]), 6);
        chans.b = widen(CH_W'(word[4:0]), 5);
      end
      FMT_RGB888, FMT_XRGB: begin
        chans.r = word[23:16];
        chans.g = word[15:8];
        chans.b = word[7:0];
      end
      FMT_ARGB8565: begin
        chans.a = word[23:16];
        chans.r = widen(CH_W'(word[15:11]), 5);
        chans.g = widen(CH_W'(word[10:5]), 6);
        chans.b = widen(CH_W'(word[4:0]), 5);
        a_kind  = ALPHA_SCALED;
      end
      FMT_ARGB8888: begin
        chans.a = word[31:24];
        chans.r = word[23:16];
        chans.g = word[15:8];
        chans.b = word[7:0];
        a_kind  = ALPHA_SCALED;
      end
      FMT_ARGB1555: begin
        chans.a = {CH_W{word[15]}};
        chans.r = widen(CH_W'(word[14:10]), 5);
        chans.g = widen(CH_W'(word[9:5]), 5);
        chans.b = widen(CH_W'(word[4:0]), 5);
        a_kind  = ALPHA_DIRECT;
      end
      FMT_ARGB4444: begin
        chans.a = widen(CH_W'(word[15:12]), 4);
        chans.r = widen(CH_W'(word[11:8]), 4);
        chans.g = widen(CH_W'(word[7:4]), 4);
        chans.b = widen(CH_W'(word[3:0]), 4);
        a_kind  = ALPHA_DIRECT;
      end
      default: begin
        known  = 1'b0;
        a_kind = ALPHA_DIRECT;
      end
    endcase
  end
endmodule

// File: rtl/pix_alpha_scale.sv
module pix_alpha_scale
  import pix_fmt_pkg::*;
(
  input  logic [CH_W-1:0] a_raw,
  input  alpha_kind_e     a_kind,
  input  logic            full_range,
  output logic [CH_W-1:0] a_out
);
  localparam logic [CH_W-1:0] HALF = {1'b1, {(CH_W-1){1'b0}}};

  logic [CH_W-1:0] clamped;
  logic [CH_W:0]   doubled;

  always_comb begin
    clamped = (a_raw > HALF) ? HALF : a_raw;
    // 2*c, minus one only at the clamp point so that HALF lands on all ones
    doubled = {clamped, 1'b0} - {{CH_W{1'b0}}, clamped[CH_W-1]};
    case (a_kind)
      ALPHA_OPAQUE: a_out = '1;
      ALPHA_SCALED: a_out = full_range ? a_raw : doubled[CH_W-1:0];
      default:      a_out = a_raw;
    endcase
  end
endmodule

// File: rtl/pix_fmt_expand.sv
module pix_fmt_expand
  import pix_fmt_pkg::*;
#(
  parameter int CTL_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic [CTL_W-1:0]  in_ctl,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_argb,
  output logic              out_unknown
);
  logic                 rst_sync_n;
  logic [CTL_FMT_W-1:0] fmt_code;
  logic [WORD_W-1:0]    norm_word;
  argb_t                chans;
  alpha_kind_e          a_kind;
  logic                 known;
  logic [CH_W-1:0]      alpha;
  argb_t                pix;
  logic                 unused_ctl;

  argb_t argb_d, argb_q;
  logic  unk_d, unk_q;
  logic  vld_d, vld_q;

  assign fmt_code   = in_ctl[CTL_FMT_LSB +: CTL_FMT_W];
  assign unused_ctl = ^in_ctl;

  pix_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pix_byte_order u_order (
    .word_in  (in_word),
    .big_end  (in_ctl[CTL_BIG_END]),
    .fmt_code (fmt_code),
    .word_out (norm_word)
  );

  pix_chan_unpack u_unpack (
    .word     (norm_word),
    .fmt_code (fmt_code),
    .chans    (chans),
    .a_kind   (a_kind),
    .known    (known)
  );

  pix_alpha_scale u_alpha (
    .a_raw      (chans.a),
    .a_kind     (a_kind),
    .full_range (in_ctl[CTL_ARANGE]),
    .a_out      (alpha)
  );

  always_comb begin
    pix.a = alpha;
    pix.g = chans.g;
    if (in_ctl[CTL_RB_SWAP]) begin
      pix.r = chans.b;
      pix.b = chans.r;
    end else begin
      pix.r = chans.r;
      pix.b = chans.b;
    end
    if (!known) pix = '0;
  end

  // Next-state: capture only on a strobe.
  always_comb begin
    vld_d  = in_valid;
    argb_d = argb_q;
    unk_d  = unk_q;
    if (in_valid) begin
      argb_d = pix;
      unk_d  = ~known;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      argb_q <= '0;
      unk_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      argb_q <= argb_d;
      unk_q  <= unk_d;
    end
  end

  assign out_valid   = vld_q;
  assign out_argb    = argb_q;
  assign out_unknown = unk_q;
endmodule

// File: rtl/pix_fmt_expand_chk.sv
module pix_fmt_expand_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic [31:0] in_ctl,
  input logic        out_valid,
  input logic [31:0] out_argb,
  input logic        out_unknown
);
  logic unused_in;
  assign unused_in = ^{in_word[30:0], in_ctl[31:24], in_ctl[22:7]};

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R9
  AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R9
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_argb) && $stable(out_unknown)));  // R9
  AST_UNKNOWN_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    out_unknown |-> (out_argb == 32'h0));  // R8
  AST_OPAQUE_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ctl[4:0] <= 5'd2)) |=> (out_argb[31:24] == 8'hFF));  // R1
  AST_ONEBIT_ALPHA: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ctl[4:0] == 5'd6)) |=>
      ((out_argb[31:24] == 8'h00) || (out_argb[31:24] == 8'hFF)));  // R3
  AST_HALF_RANGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_ctl[4:0] == 5'd5) && !in_ctl[5] && !in_ctl[23] && in_word[31])
      |=> (out_argb[31:24] == 8'hFF));  // R7
endmodule

bind pix_fmt_expand pix_fmt_expand_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .in_word     (in_word),
  .in_ctl      (in_ctl),
  .out_valid   (out_valid),
  .out_argb    (out_argb),
  .out_unknown (out_unknown)
);

// File: tb/pix_fmt_expand_tb.sv
module pix_fmt_expand_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_word;
  logic [31:0] in_ctl;
  logic        out_valid;
  logic [31:0] out_argb;
  logic        out_unknown;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  localparam logic [31:0] BE = 32'h0080_0000;
  localparam logic [31:0] SW = 32'h0000_0040;
  localparam logic [31:0] AR = 32'h0000_0020;

  pix_fmt_expand #(.CTL_W(32)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_word     (in_word),
    .in_ctl      (in_ctl),
    .out_valid   (out_valid),
    .out_argb    (out_argb),
    .out_unknown (out_unknown)
  );

  always #5 clk = ~clk;

  task automatic px(input logic [31:0] w, input logic [31:0] c,
                    input logic [31:0] exp, input logic exp_unk, input string req);
    @(negedge clk);
    in_word  = w;
    in_ctl   = c;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || out_argb !== exp || out_unknown !== exp_unk) begin
      failures++;
      $display("FAIL %s: word=%h ctl=%h got v=%b argb=%h unk=%b exp v=1 argb=%h unk=%b",
               req, w, c, out_valid, out_argb, out_unknown, exp, exp_unk);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_ctl = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_argb !== 32'h0 || out_unknown !== 1'b0) begin
      failures++;
      $display("FAIL R10: got v=%b argb=%h unk=%b exp 0/00000000/0",
               out_valid, out_argb, out_unknown);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_no_alpha;
    px(32'h0000_F800, 32'h0, 32'hFFFF_0000, 1'b0, "R1 565 red");
    px(32'h0000_07E0, 32'h0, 32'hFF00_FF00, 1'b0, "R1 565 green");
    px(32'h0000_001F, 32'h0, 32'hFF00_00FF, 1'b0, "R1 565 blue");
    px(32'h0012_3456, 32'h1, 32'hFF12_3456, 1'b0, "R1 888");
    px(32'hAB12_3456, 32'h2, 32'hFF12_3456, 1'b0, "R1 x888");
  endtask

  task automatic t_widen;
    px(32'h0000_8000, 32'h0, 32'hFF84_0000, 1'b0, "R4 5-bit 10000");
    px(32'h0000_0000, 32'h0, 32'hFF00_0000, 1'b0, "R4 zero");
  endtask

  task automatic t_alpha8;
    px(32'h8012_3456, 32'h5 | AR, 32'h8012_3456, 1'b0, "R2 8888 full");
    px(32'h00AA_F800, 32'h4 | AR, 32'hAAFF_0000, 1'b0, "R2 8565 full");
    px(32'h4012_3456, 32'h5, 32'h8012_3456, 1'b0, "R7 half 0x40");
    px(32'h7F00_0000, 32'h5, 32'hFE00_0000, 1'b0, "R7 half 0x7F");
    px(32'h8000_0000, 32'h5, 32'hFF00_0000, 1'b0, "R7 half 0x80");
    px(32'h9000_0000, 32'h5, 32'hFF00_0000, 1'b0, "R7 clamp 0x90");
    px(32'h0000_0000, 32'h5, 32'h0000_0000, 1'b0, "R7 half zero");
    px(32'h0020_001F, 32'h4, 32'h4000_00FF, 1'b0, "R7 8565 half");
  endtask

  task automatic t_small_alpha;
    px(32'h0000_8000, 32'h6, 32'hFF00_0000, 1'b0, "R3 1555 a=1");
    px(32'h0000_7FFF, 32'h6, 32'h00FF_FFFF, 1'b0, "R3 1555 a=0");
    px(32'h0000_1234, 32'h7, 32'h1122_3344, 1'b0, "R3 4444");
  endtask

  task automatic t_range_ignored;
    px(32'h0000_F000, 32'h7, 32'hFF00_0000, 1'b0, "R11 4444 range clear");
    px(32'h0000_F000, 32'h7 | AR, 32'hFF00_0000, 1'b0, "R11 4444 range set");
    px(32'h0000_8000, 32'h6 | AR, 32'hFF00_0000, 1'b0, "R11 1555 range set");
    px(32'h0012_3456, 32'h1 | AR, 32'hFF12_3456, 1'b0, "R11 888 range set");
  endtask

  task automatic t_byte_order;
    px(32'h5634_1280, 32'h5 | AR | BE, 32'h8012_3456, 1'b0, "R5 8888 be");
    px(32'h0000_00F8, 32'h0 | BE, 32'hFFFF_0000, 1'b0, "R5 565 be");
    px(32'h0056_3412, 32'h1 | BE, 32'hFF12_3456, 1'b0, "R5 888 be");
    px(32'h0000_F8AA, 32'h4 | AR | BE, 32'hAAFF_0000, 1'b0, "R5 8565 be");
  endtask

  task automatic t_swap;
    px(32'h0012_3456, 32'h2 | SW, 32'hFF56_3412, 1'b0, "R6 swap x888");
    px(32'h0012_3456, 32'h2 | SW | BE, 32'hFF00_1234, 1'b0, "R6 xbgr");
    px(32'h4433_2211, 32'h5 | SW | BE | AR, 32'h1144_3322, 1'b0, "R6 abgr");
  endtask

  task automatic t_unknown;
    px(32'hFFFF_FFFF, 32'h3, 32'h0, 1'b1, "R8 code 3");
    px(32'hFFFF_FFFF, 32'h8, 32'h0, 1'b1, "R8 code 8");
    px(32'h0000_1234, 32'h7, 32'h1122_3344, 1'b0, "R8 flag clears");
  endtask

  task automatic t_hold;
    px(32'h0000_1234, 32'h7, 32'h1122_3344, 1'b0, "R9 setup");
    in_word = 32'hDEAD_BEEF;
    in_ctl  = 32'h3;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_argb !== 32'h1122_3344 || out_unknown !== 1'b0) begin
      failures++;
      $display("FAIL R9 hold: got v=%b argb=%h unk=%b exp v=0 argb=11223344 unk=0",
               out_valid, out_argb, out_unknown);
    end
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_argb !== 32'h1122_3344) begin
      failures++;
      $display("FAIL R9 hold2: got v=%b argb=%h exp v=0 argb=11223344",
               out_valid, out_argb);
    end
  endtask

  initial begin
    t_reset();
    t_no_alpha();
    t_widen();
    t_alpha8();
    t_small_alpha();
    t_range_ignored();
    t_byte_order();
    t_swap();
    t_unknown();
    t_hold();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog: got hung run exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule